// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block steers every access that falls in the top part of the first megabyte of the address space. It holds a set of small programmable attribute fields, written one byte at a time through a configuration write port. For each access it looks at the 20-bit address, the write strobe and the processor's system-management state. It then reports whether the access is served by DRAM or handed on to the legacy bus. It also reports whether the matched region is mapped read-only.

The upper area is split into three parts. The first is a 128 KB video window at 0xA0000–0xBFFFF, controlled by a system-management RAM control byte. The second is twelve 16 KB expansion segments at 0xC0000–0xEFFFF. The third is one 64 KB top segment at 0xF0000–0xFFFFF. Each segment carries a 2-bit attribute code, and two codes are packed into each configuration byte.

The routing decision is purely combinational on the stored fields, so a new setting governs any access presented in the cycle after the write. Only the configuration bits that influence routing are kept in flops.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset every attribute code is 0 and the control byte at offset 0x72 holds 0x02, so all accesses from 0xA0000 up are forwarded (to_dram=0, read_only=0) whatever the SMM input is.
- R2: Any address below 0xA0000 gives to_dram=1 and read_only=0, for reads and writes alike.
- R3: Attribute code 3 sends both reads and writes of its segment to DRAM, with read_only=0.
- R4: Attribute code 1 marks the segment read-only (read_only=1). Reads go to DRAM and writes are forwarded (to_dram=0).
- R5: Attribute codes 0 and 2 forward both reads and writes, with read_only=0.
- R6: The 64 KB segment at 0xF0000–0xFFFFF takes its code from bits 5:4 of the byte at offset 0x59. Bits 3:0 of that byte have no effect.
- R7: The 16 KB segment i (i=0..11, base 0xC0000 + i·0x4000) takes its code from the byte at offset 0x5A + i/2. It uses bits 1:0 for even i and bits 5:4 for odd i. Bits 3:2 and 7:6 have no effect.
- R8: In the window 0xA0000–0xBFFFF, to_dram=1 when bit 6 of the byte at 0x72 is set, or when bit 3 of that byte is set and smm_active is high. Otherwise the access is forwarded. read_only is always 0 in this window.
- R9: A configuration write to any offset other than 0x59–0x5F and 0x72 changes no routing decision.
- R10: The routing of an access presented in the cycle after a configuration write reflects the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 8 | Configuration byte value |
| smm_active | input | 1 | Processor is in system-management mode |
| acc_addr | input | 20 | Address of the current access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| to_dram | output | 1 | Access is served by DRAM |
| read_only | output | 1 | Matched segment is mapped read-only |

## Verification
The bench goes after nibble selection, because a decoder that swapped even and odd segments, or used bits 3:2, would route the wrong 16 KB half. It also checks code 1 writes, where a design that treats read-only as read-write would let writes reach DRAM. The video-window test drives the enable bit with SMM low, then the same bit with SMM high, then the open bit alone. A design that ignores the SMM qualifier, or the open bit, misroutes one of these. Writes to neighbouring offsets 0x58, 0x60, 0x71 and 0x73 expose an off-by-one range decode. Probing right after each write exposes a design that registers its outputs.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    typedef enum logic [1:0] {
        ATTR_FWD_A = 2'd0,
        ATTR_RO    = 2'd1,
        ATTR_FWD_B = 2'd2,
        ATTR_RW    = 2'd3
    } attr_e;

    typedef enum logic [1:0] {
        RGN_LOW   = 2'd0,
        RGN_VIDEO = 2'd1,
        RGN_SEG16 = 2'd2,
        RGN_TOP64 = 2'd3
    } region_e;

endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs #(
    parameter int              ADDR_W       = 8,
    parameter logic [7:0]      ATTR_BASE    = 8'h59,
    parameter int              ATTR_BYTES   = 7,
    parameter logic [7:0]      SMRAM_OFS    = 8'h72,
    parameter logic [7:0]      SMRAM_RST    = 8'h02,
    parameter int              OPEN_BIT     = 6,
    parameter int              SMM_EN_BIT   = 3,
    parameter int              TOP_LSB      = 4,
    localparam int             NSEG         = 2 * (ATTR_BYTES - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr_en,
    input  logic [ADDR_W-1:0]       cfg_wr_addr,
    input  logic [7:0]              cfg_wr_data,
    output logic [1:0]              top_code,
    output logic [NSEG-1:0][1:0]    seg_code,
    output logic                    smm_open,
    output logic                    smm_en
);

    localparam logic [ADDR_W-1:0] TOP_OFS = ADDR_W'(ATTR_BASE);
    localparam logic [ADDR_W-1:0] SMR_OFS = ADDR_W'(SMRAM_OFS);

    logic unused_data_bits;
    assign unused_data_bits = ^{cfg_wr_data[7], cfg_wr_data[2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_code <= '0;
        end else if (cfg_wr_en && cfg_wr_addr == TOP_OFS) begin
            top_code <= cfg_wr_data[TOP_LSB +: 2];
        end
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam logic [ADDR_W-1:0] SEG_OFS = ADDR_W'(ATTR_BASE + 1 + i / 2);
        localparam int                SEG_LSB = (i % 2) * 4;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_code[i] <= '0;
            end else if (cfg_wr_en && cfg_wr_addr == SEG_OFS) begin
                seg_code[i] <= cfg_wr_data[SEG_LSB +: 2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smm_open <= SMRAM_RST[OPEN_BIT];
            smm_en   <= SMRAM_RST[SMM_EN_BIT];
        end else if (cfg_wr_en && cfg_wr_addr == SMR_OFS) begin
            smm_open <= cfg_wr_data[OPEN_BIT];
            smm_en   <= cfg_wr_data[SMM_EN_BIT];
        end
    end

    // R9: writes outside the attribute range and the control byte leave every field alone
    p_foreign_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr != SMR_OFS &&
         (cfg_wr_addr < TOP_OFS || cfg_wr_addr >= ADDR_W'(ATTR_BASE + ATTR_BYTES)))
        |=> ($stable(top_code) && $stable(seg_code) && $stable(smm_open) && $stable(smm_en)));

    // R10: a control byte write is visible in the next cycle
    p_smram_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == SMR_OFS)
        |=> (smm_open == $past(cfg_wr_data[OPEN_BIT]) && smm_en == $past(cfg_wr_data[SMM_EN_BIT])));

    // R6: the top segment field follows bits 5:4 of its byte
    p_top_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == TOP_OFS)
        |=> (top_code == $past(cfg_wr_data[TOP_LSB +: 2])));

endmodule

// File: rtl/lrd_seg_lookup.sv
module lrd_seg_lookup
    import lrd_pkg::*;
#(
    parameter int  NSEG = 12,
    localparam int SLOTS = 16
) (
    input  logic [5:0]            blk,
    input  logic [1:0]            top_code,
    input  logic [NSEG-1:0][1:0]  seg_code,
    output region_e               region,
    output attr_e                 code
);

    // 16 KB block numbers of the region boundaries
    localparam logic [2:0] VIDEO_HI3 = 3'b101;   // 0xA0000 >> 17
    localparam logic [3:0] TOP_HI4   = 4'hF;     // 0xF0000 >> 16
    localparam logic [5:0] SEG_BASE  = 6'h30;    // 0xC0000 >> 14

    logic [SLOTS-1:0][1:0] slot_code;
    logic [3:0]            seg_idx;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NSEG) begin : g_used
            assign slot_code[i] = seg_code[i];
        end else begin : g_spare
            assign slot_code[i] = 2'b00;
        end
    end

    assign seg_idx = 4'(blk - SEG_BASE);

    always_comb begin
        region = RGN_LOW;
        code   = ATTR_FWD_A;
        if (blk[5:3] < VIDEO_HI3) begin
            region = RGN_LOW;
        end else if (blk[5:3] == VIDEO_HI3) begin
            region = RGN_VIDEO;
        end else if (blk[5:2] == TOP_HI4) begin
            region = RGN_TOP64;
            code   = attr_e'(top_code);
        end else begin
            region = RGN_SEG16;
            code   = attr_e'(slot_code[seg_idx]);
        end
    end

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
    import lrd_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] ATTR_BASE  = 8'h59,
    parameter int         ATTR_BYTES = 7,
    parameter logic [7:0] SMRAM_OFS  = 8'h72,
    parameter logic [7:0] SMRAM_RST  = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [7:0]        cfg_wr_data,
    input  logic              smm_active,
    input  logic [19:0]       acc_addr,
    input  logic              acc_write,
    output logic              to_dram,
    output logic              read_only
);

    localparam int NSEG = 2 * (ATTR_BYTES - 1);

    logic [1:0]           top_code;
    logic [NSEG-1:0][1:0] seg_code;
    logic                 smm_open;
    logic                 smm_en;
    region_e              region;
    attr_e                code;

    logic unused_addr_bits;
    assign unused_addr_bits = ^acc_addr[13:0];

    lrd_cfg_regs #(
        .ADDR_W     (ADDR_W),
        .ATTR_BASE  (ATTR_BASE),
        .ATTR_BYTES (ATTR_BYTES),
        .SMRAM_OFS  (SMRAM_OFS),
        .SMRAM_RST  (SMRAM_RST)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .top_code    (top_code),
        .seg_code    (seg_code),
        .smm_open    (smm_open),
        .smm_en      (smm_en)
    );

    lrd_seg_lookup #(
        .NSEG (NSEG)
    ) i_lookup (
        .blk      (acc_addr[19:14]),
        .top_code (top_code),
        .seg_code (seg_code),
        .region   (region),
        .code     (code)
    );

    always_comb begin
        to_dram   = 1'b0;
        read_only = 1'b0;
        unique case (region)
            RGN_LOW: begin
                to_dram = 1'b1;
            end
            RGN_VIDEO: begin
                to_dram = smm_open | (smm_en & smm_active);
            end
            RGN_SEG16, RGN_TOP64: begin
                unique case (code)
                    ATTR_RW: to_dram = 1'b1;
                    ATTR_RO: begin
                        to_dram   = ~acc_write;
                        read_only = 1'b1;
                    end
                    default: to_dram = 1'b0;
                endcase
            end
            default: to_dram = 1'b0;
        endcase
    end

    // R2: conventional memory below the legacy area is always DRAM
    p_low_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr < 20'hA0000) |-> (to_dram && !read_only));

    // R4: a write into a read-only segment never reaches DRAM
    p_ro_write_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (read_only && acc_write) |-> !to_dram);

    // R8: the video window is never reported read-only
    p_video_not_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[19:17] == 3'b101) |-> !read_only);

    // R8: with the window closed and no SMM qualifier, video accesses are forwarded
    p_video_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[19:17] == 3'b101 && !smm_open && !smm_active) |-> !to_dram);

endmodule

// File: tb/test_legacy_region_decoder.sv
module test_legacy_region_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        smm_active = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        to_dram;
    logic        read_only;

    int total = 0;
    int bad   = 0;
    bit cmp_en = 1'b0;
    logic [7:0] mdl [0:255];

    always #5 clk = ~clk;

    legacy_region_decoder i_legacy_region_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .smm_active  (smm_active),
        .acc_addr    (acc_addr),
        .acc_write   (acc_write),
        .to_dram     (to_dram),
        .read_only   (read_only)
    );

    // behavioural configuration space: every byte kept, only routing bytes consulted
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mdl[k] <= (k == 'h72) ? 8'h02 : 8'h00;
        end else if (cfg_wr_en) begin
            mdl[cfg_wr_addr] <= cfg_wr_data;
        end
    end

    function automatic void ref_route(input logic [19:0] a, input bit wr, input bit smm,
                                      output bit d, output bit ro, output string tag);
        int idx;
        int code;
        logic [7:0] b;
        d = 0; ro = 0; code = 0;
        if (a < 20'hA0000) begin
            d = 1; tag = "R2";
        end else if (a < 20'hC0000) begin
            d = mdl['h72][6] || (mdl['h72][3] && smm); tag = "R8";
        end else begin
            if (a >= 20'hF0000) begin
                code = int'(mdl['h59][5:4]); tag = "R6";
            end else begin
                idx  = int'((a - 20'hC0000) / 20'h4000);
                b    = mdl['h5A + idx / 2];
                code = (idx % 2 == 1) ? int'(b[5:4]) : int'(b[1:0]);
                tag  = "R7";
            end
            d  = (code == 3) || (code == 1 && !wr);
            ro = (code == 1);
        end
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        bit ed, ero;
        string tg;
        if (cmp_en) begin
            ref_route(acc_addr, acc_write, smm_active, ed, ero, tg);
            total++;
            if (to_dram !== ed || read_only !== ero) begin
                bad++;
                $display("FAIL %s model addr=%h wr=%0b smm=%0b actual dram=%0b ro=%0b expected dram=%0b ro=%0b",
                         tg, acc_addr, acc_write, smm_active, to_dram, read_only, ed, ero);
            end
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic probe(input string req, input logic [19:0] a, input bit wr, input bit smm,
                         input bit ed, input bit ero);
        acc_addr = a; acc_write = wr; smm_active = smm;
        @(negedge clk);
        total++;
        if (to_dram !== ed || read_only !== ero) begin
            bad++;
            $display("FAIL %s addr=%h wr=%0b smm=%0b actual dram=%0b ro=%0b expected dram=%0b ro=%0b",
                     req, a, wr, smm, to_dram, read_only, ed, ero);
        end
        #1;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        probe("R1", 20'hC0000, 0, 0, 0, 0);
        probe("R1", 20'hF0000, 0, 1, 0, 0);
        probe("R1", 20'hA0000, 0, 1, 0, 0);
        probe("R1", 20'hEFFFF, 1, 0, 0, 0);
        probe("R2", 20'h12345, 1, 0, 1, 0);

        // R6 top segment, R10 visible in the very next cycle
        cfg_write(8'h59, 8'h30);
        probe("R10", 20'hF8000, 1, 0, 1, 0);
        cfg_write(8'h59, 8'h0F);
        probe("R6", 20'hF0000, 0, 0, 0, 0);
        cfg_write(8'h59, 8'h10);
        probe("R4", 20'hFFFFF, 1, 0, 0, 1);
        probe("R4", 20'hFFFFF, 0, 0, 1, 1);

        // R7 nibble selection with R3 and R4 codes
        cfg_write(8'h5A, 8'h31);
        probe("R4", 20'hC0000, 0, 0, 1, 1);
        probe("R4", 20'hC0000, 1, 0, 0, 1);
        probe("R3", 20'hC4000, 1, 0, 1, 0);
        probe("R7", 20'hC7FFF, 0, 0, 1, 0);
        cfg_write(8'h5F, 8'h3E);
        probe("R5", 20'hE8000, 0, 0, 0, 0);
        probe("R7", 20'hEFFFF, 1, 0, 1, 0);
        cfg_write(8'h5B, 8'h0C);
        probe("R5", 20'hC8000, 0, 0, 0, 0);

        // R8 video window
        cfg_write(8'h72, 8'h08);
        probe("R8", 20'hA0000, 0, 0, 0, 0);
        probe("R8", 20'hBFFFF, 1, 1, 1, 0);
        cfg_write(8'h72, 8'h40);
        probe("R8", 20'hB0000, 0, 0, 1, 0);
        cfg_write(8'h72, 8'hB7);
        probe("R8", 20'hA8000, 1, 1, 0, 0);

        // R9 neighbouring offsets have no effect
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h71, 8'hFF);
        cfg_write(8'h73, 8'hFF);
        probe("R9", 20'hC0000, 0, 0, 1, 1);
        probe("R9", 20'hF0000, 0, 0, 1, 1);
        probe("R9", 20'hA0000, 0, 1, 0, 0);
        probe("R9", 20'hC8000, 1, 0, 0, 0);
        probe("R2", 20'h9FFFF, 1, 1, 1, 0);

        // mixed traffic, checked by the every-clock model
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 3 == 0)
                cfg_write(8'(8'h55 + $urandom % 32), 8'($urandom));
            acc_addr   = 20'(20'h90000 + $urandom % 20'h70000);
            acc_write  = 1'($urandom);
            smm_active = 1'($urandom);
            @(negedge clk);
            #1;
        end

        cmp_en = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule